// File: doc/BRIEF.md
# ADC Result Computation Engine

This block sits after an analog-to-digital converter and post-processes its stream of signed results. Each result arrives with a one-cycle valid strobe. A mode input selects what happens to it. In basic mode it is passed straight through. In accumulate mode it is summed. In average mode it is summed until a repeat count is reached and then scaled. Burst average mode does the same while asking the converter for back-to-back conversions. Low-pass filter mode applies a first-order filter.

One saturating accumulator and one saturating sample counter serve all five modes. The repeat setting is given as a base-two logarithm, so that scaling by the repeat count is an arithmetic right shift. Whenever a mode produces a final value, that value can be compared against a lower and an upper threshold under a selectable condition. A match raises a one-cycle interrupt pulse.

All outputs are registered and change at the clock edge that accepts a result.

Top module: `adc_compute_engine`

## Requirements
- R1: After reset, out_value, acc_value and sample_count are zero, and out_valid, thr_irq and retrig_req are low.
- R2: With mode = 0 (basic), each accepted result appears sign-extended on out_value with out_valid high in the cycle after the strobe, and the threshold test runs on every result.
- R3: With mode = 1 (accumulate), each result is added to acc_value and sample_count rises by one. out_value follows acc_value with out_valid on every result, thr_irq never rises, and the state is never cleared automatically.
- R4: With mode = 2 (average) and repeat N = 2^rpt_log2, out_valid and the threshold test occur only on the result that brings sample_count to N. out_value is then acc_value arithmetically shifted right by rpt_log2, rounding toward minus infinity. The next result starts a new sum, so acc_value equals that result and sample_count equals 1.
- R5: With mode = 3 (burst average), the arithmetic is as in R4. In addition, retrig_req is high for one cycle after each accepted result whose new count is below N, and it stays low after the result that completes the count.
- R6: With mode = 4 (low-pass), each result updates acc <= acc - (acc >>> rpt_log2) + result. Once sample_count >= N, every result produces out_value = acc >>> rpt_log2 with out_valid and a threshold test. The state is never cleared automatically.
- R7: thr_cond selects the interrupt condition: 0 means value < thr_lo, 1 means value > thr_hi, 2 means either of those, and 3 means thr_lo <= value <= thr_hi. thr_irq is a one-cycle pulse that only accompanies out_valid.
- R8: The accumulator is 18 bits signed and saturates at +131071 and -131072 instead of wrapping.
- R9: sample_count saturates at 255.
- R10: A result whose mode differs from the mode of the previous accepted result starts from a cleared accumulator and counter.
- R11: In a cycle with no strobe, acc_value, sample_count and out_value hold, and out_valid, thr_irq and retrig_req are low one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Result strobe |
| res_data | input | 12 | Signed conversion result |
| mode | input | 3 | 0 basic, 1 accumulate, 2 average, 3 burst average, 4 low-pass |
| rpt_log2 | input | 3 | Log2 of the repeat count (0..7) |
| thr_lo | input | 12 | Signed lower threshold |
| thr_hi | input | 12 | Signed upper threshold |
| thr_cond | input | 2 | Interrupt condition select |
| out_value | output | 18 | Signed computed value |
| out_valid | output | 1 | out_value updated this cycle |
| thr_irq | output | 1 | Threshold interrupt pulse |
| retrig_req | output | 1 | Request for another conversion (burst mode) |
| acc_value | output | 18 | Signed accumulator contents |
| sample_count | output | 8 | Sample counter |

## Verification
The hardest conditions to reach from the ports are the saturation limits. The accumulator must be driven past plus and minus 2^17, and the counter past 255. Random results almost never do this within a short run, so directed sequences feed long runs of full-scale results, and of zeros, in accumulate mode. The restart rules after a completed average and after a mode change hinge on a single sample. Random blocks of samples therefore switch mode and repeat count between blocks, and every result is compared with a bench model of the accumulator, counter and threshold test.

// File: rtl/adc_ce_pkg.sv
package adc_ce_pkg;
  localparam int RES_W = 12;
  localparam int ACC_W = 18;
  localparam int CNT_W = 8;
  localparam int SHW   = 3;

  typedef enum logic [2:0] {
    MD_BASIC = 3'd0,
    MD_ACCUM = 3'd1,
    MD_AVG   = 3'd2,
    MD_BURST = 3'd3,
    MD_LPF   = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    TC_BELOW   = 2'd0,
    TC_ABOVE   = 2'd1,
    TC_OUTSIDE = 2'd2,
    TC_INSIDE  = 2'd3
  } cond_e;

  typedef logic signed [ACC_W-1:0] acc_t;
  typedef logic [CNT_W-1:0]        cnt_t;

  localparam acc_t ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam acc_t ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  function automatic acc_t sext_res(logic signed [RES_W-1:0] r);
    return {{(ACC_W-RES_W){r[RES_W-1]}}, r};
  endfunction

  // Sum with one guard bit; clamp when the guard and sign bits disagree.
  function automatic acc_t sat_add(acc_t a, acc_t b);
    logic signed [ACC_W:0] s;
    s = {a[ACC_W-1], a} + {b[ACC_W-1], b};
    if (s[ACC_W] != s[ACC_W-1]) return s[ACC_W] ? ACC_MIN : ACC_MAX;
    return s[ACC_W-1:0];
  endfunction

  // First-order filter step: leak 1/2^k of the state, then add the input.
  function automatic acc_t lpf_step(acc_t a, acc_t x, logic [SHW-1:0] k);
    acc_t decay;
    decay = a >>> k;
    return sat_add(a - decay, x);
  endfunction

  function automatic cnt_t cnt_inc(cnt_t c);
    return (&c) ? c : c + 1'b1;
  endfunction

  function automatic cnt_t rpt_of(logic [SHW-1:0] k);
    return {{(CNT_W-1){1'b0}}, 1'b1} << k;
  endfunction

  function automatic logic thr_hit(acc_t v, acc_t lo, acc_t hi, logic [1:0] c);
    logic below, above;
    below = (v < lo);
    above = (v > hi);
    case (cond_e'(c))
      TC_BELOW:   return below;
      TC_ABOVE:   return above;
      TC_OUTSIDE: return below | above;
      default:    return !below && !above;
    endcase
  endfunction
endpackage

// File: rtl/adc_ce_accum.sv
module adc_ce_accum
  import adc_ce_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_vld,
  input  logic [2:0]              mode,
  input  logic [SHW-1:0]          k,
  input  logic                    fresh,
  input  logic signed [RES_W-1:0] smp,
  output acc_t                    acc_q,
  output cnt_t                    cnt_q,
  output acc_t                    acc_nxt,
  output cnt_t                    cnt_nxt
);
  acc_t base_acc;
  cnt_t base_cnt;
  acc_t x;

  always_comb begin
    base_acc = fresh ? '0 : acc_q;
    base_cnt = fresh ? '0 : cnt_q;
    x        = sext_res(smp);
    case (mode)
      MD_ACCUM, MD_AVG, MD_BURST: acc_nxt = sat_add(base_acc, x);
      MD_LPF:                     acc_nxt = lpf_step(base_acc, x, k);
      default:                    acc_nxt = x;
    endcase
    cnt_nxt = cnt_inc(base_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (smp_vld) begin
      acc_q <= acc_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !smp_vld |=> $stable(acc_q) && $stable(cnt_q)); // R11
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) smp_vld && !fresh && !(&cnt_q) |=> cnt_q == $past(cnt_q) + 1'b1); // R3
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n) smp_vld && !fresh && (&cnt_q) |=> (&cnt_q)); // R9
endmodule

// File: rtl/adc_ce_sched.sv
module adc_ce_sched
  import adc_ce_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           smp_vld,
  input  logic [2:0]     mode,
  input  logic [SHW-1:0] k,
  input  cnt_t           cnt_nxt,
  output logic           fresh,
  output logic           upd,
  output logic           test_en,
  output logic           use_shift,
  output logic           retrig_q
);
  logic [2:0] mode_q;
  logic       clr_pend_q;
  logic       reached;
  logic       avg_like;

  always_comb begin
    reached   = (cnt_nxt >= rpt_of(k));
    avg_like  = (mode == MD_AVG) || (mode == MD_BURST);
    fresh     = clr_pend_q || (mode != mode_q);
    use_shift = avg_like || (mode == MD_LPF);
    case (mode)
      MD_ACCUM: begin upd = 1'b1;    test_en = 1'b0;    end
      MD_AVG, MD_BURST, MD_LPF:
                begin upd = reached; test_en = reached; end
      default:  begin upd = 1'b1;    test_en = 1'b1;    end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MD_BASIC;
      clr_pend_q <= 1'b0;
      retrig_q   <= 1'b0;
    end else begin
      retrig_q <= smp_vld && (mode == MD_BURST) && !reached;
      if (smp_vld) begin
        mode_q     <= mode;
        clr_pend_q <= avg_like && reached;
      end
    end
  end

  AST_NO_RETRIG_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !smp_vld |=> !retrig_q); // R11
  AST_RETRIG_ONLY_BURST: assert property (@(posedge clk) disable iff (!rst_n) retrig_q |-> mode_q == MD_BURST); // R5
endmodule

// File: rtl/adc_ce_thresh.sv
module adc_ce_thresh
  import adc_ce_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_vld,
  input  logic                    upd,
  input  logic                    test_en,
  input  acc_t                    val,
  input  logic signed [RES_W-1:0] thr_lo,
  input  logic signed [RES_W-1:0] thr_hi,
  input  logic [1:0]              thr_cond,
  output acc_t                    out_q,
  output logic                    vld_q,
  output logic                    irq_q
);
  logic hit;

  always_comb hit = thr_hit(val, sext_res(thr_lo), sext_res(thr_hi), thr_cond);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      vld_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      vld_q <= smp_vld && upd;
      irq_q <= smp_vld && upd && test_en && hit;
      if (smp_vld && upd) out_q <= val;
    end
  end

  AST_IRQ_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n) irq_q |-> vld_q); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !smp_vld |=> $stable(out_q) && !vld_q); // R11
endmodule

// File: rtl/adc_compute_engine.sv
module adc_compute_engine
  import adc_ce_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    res_valid,
  input  logic signed [RES_W-1:0] res_data,
  input  logic [2:0]              mode,
  input  logic [SHW-1:0]          rpt_log2,
  input  logic signed [RES_W-1:0] thr_lo,
  input  logic signed [RES_W-1:0] thr_hi,
  input  logic [1:0]              thr_cond,
  output logic signed [ACC_W-1:0] out_value,
  output logic                    out_valid,
  output logic                    thr_irq,
  output logic                    retrig_req,
  output logic signed [ACC_W-1:0] acc_value,
  output logic [CNT_W-1:0]        sample_count
);
  acc_t acc_q, acc_nxt, val;
  cnt_t cnt_q, cnt_nxt;
  logic fresh, upd, test_en, use_shift;
  cnt_t rpt_now;

  adc_ce_sched u_sched (
    .clk(clk), .rst_n(rst_n), .smp_vld(res_valid), .mode(mode), .k(rpt_log2),
    .cnt_nxt(cnt_nxt), .fresh(fresh), .upd(upd), .test_en(test_en),
    .use_shift(use_shift), .retrig_q(retrig_req)
  );

  adc_ce_accum u_accum (
    .clk(clk), .rst_n(rst_n), .smp_vld(res_valid), .mode(mode), .k(rpt_log2),
    .fresh(fresh), .smp(res_data), .acc_q(acc_q), .cnt_q(cnt_q),
    .acc_nxt(acc_nxt), .cnt_nxt(cnt_nxt)
  );

  always_comb begin
    val     = use_shift ? (acc_nxt >>> rpt_log2) : acc_nxt;
    rpt_now = rpt_of(rpt_log2);
  end

  adc_ce_thresh u_thresh (
    .clk(clk), .rst_n(rst_n), .smp_vld(res_valid), .upd(upd), .test_en(test_en),
    .val(val), .thr_lo(thr_lo), .thr_hi(thr_hi), .thr_cond(thr_cond),
    .out_q(out_value), .vld_q(out_valid), .irq_q(thr_irq)
  );

  assign acc_value    = acc_q;
  assign sample_count = cnt_q;

  AST_ACCUM_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n) res_valid && mode == MD_ACCUM |=> !thr_irq && out_valid); // R3
  AST_AVG_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n) res_valid && mode == MD_AVG |=> out_valid == (sample_count >= $past(rpt_now))); // R4
  AST_BASIC_PASS: assert property (@(posedge clk) disable iff (!rst_n) res_valid && mode == MD_BASIC |=> out_valid && out_value == acc_value); // R2
endmodule

// File: tb/adc_compute_engine_tb.sv
module adc_compute_engine_tb;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               res_valid = 1'b0;
  logic signed [11:0] res_data = '0;
  logic [2:0]         mode = 3'd0;
  logic [2:0]         rpt_log2 = 3'd0;
  logic signed [11:0] thr_lo = '0;
  logic signed [11:0] thr_hi = '0;
  logic [1:0]         thr_cond = 2'd0;
  logic signed [17:0] out_value;
  logic               out_valid, thr_irq, retrig_req;
  logic signed [17:0] acc_value;
  logic [7:0]         sample_count;

  int tests = 0, fails = 0;
  bit finished = 0;
  // bench model state
  int m_acc = 0, m_cnt = 0, m_mode = 0, e_out = 0;
  bit m_clr = 0;

  always #10 clk = ~clk;

  adc_compute_engine u_dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .mode(mode), .rpt_log2(rpt_log2), .thr_lo(thr_lo), .thr_hi(thr_hi),
    .thr_cond(thr_cond), .out_value(out_value), .out_valid(out_valid),
    .thr_irq(thr_irq), .retrig_req(retrig_req), .acc_value(acc_value),
    .sample_count(sample_count)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clamp18(input int v);
    if (v > 131071) return 131071;
    if (v < -131072) return -131072;
    return v;
  endfunction

  function automatic string tag_of(input int m);
    case (m)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R2";
    endcase
  endfunction

  task automatic cfg(input int md, input int k, input int lo, input int hi, input int c);
    @(negedge clk);
    mode = md[2:0]; rpt_log2 = k[2:0]; thr_lo = lo[11:0]; thr_hi = hi[11:0]; thr_cond = c[1:0];
  endtask

  task automatic push(input int x, input string tag);
    int md, k, lo, hi, b_acc, b_cnt, n_acc, n_cnt, val;
    bit fresh, reached, upd, tst, hit, e_irq, e_rt;
    md = int'(mode); k = int'(rpt_log2);
    lo = int'(thr_lo); hi = int'(thr_hi);
    fresh = m_clr || (md != m_mode);
    b_acc = fresh ? 0 : m_acc;
    b_cnt = fresh ? 0 : m_cnt;
    if (md == 1 || md == 2 || md == 3) n_acc = clamp18(b_acc + x);
    else if (md == 4) n_acc = clamp18(b_acc - (b_acc >>> k) + x);
    else n_acc = x;
    n_cnt = (b_cnt >= 255) ? 255 : b_cnt + 1;
    reached = (n_cnt >= (1 << k));
    upd = (md <= 1) ? 1'b1 : reached;
    tst = (md == 0) ? 1'b1 : ((md == 1) ? 1'b0 : reached);
    val = (md >= 2) ? (n_acc >>> k) : n_acc;
    case (int'(thr_cond))
      0: hit = val < lo;
      1: hit = val > hi;
      2: hit = (val < lo) || (val > hi);
      default: hit = (val >= lo) && (val <= hi);
    endcase
    e_irq = upd && tst && hit;
    e_rt = (md == 3) && !reached;
    m_clr = (md == 2 || md == 3) && reached;
    m_mode = md; m_acc = n_acc; m_cnt = n_cnt;
    if (upd) e_out = val;
    @(negedge clk); res_valid = 1'b1; res_data = x[11:0];
    @(negedge clk); res_valid = 1'b0;
    chk(int'(acc_value) == n_acc, tag, int'(acc_value), n_acc);
    chk(int'(sample_count) == n_cnt, tag, int'(sample_count), n_cnt);
    chk(out_valid == upd, tag, int'(out_valid), int'(upd));
    chk(int'(out_value) == e_out, tag, int'(out_value), e_out);
    chk(thr_irq == e_irq, {tag, "/R7"}, int'(thr_irq), int'(e_irq));
    chk(retrig_req == e_rt, {tag, "/R5"}, int'(retrig_req), int'(e_rt));
  endtask

  task automatic idle_check;
    @(negedge clk);
    chk(!out_valid && !thr_irq && !retrig_req, "R11 strobes", int'({out_valid, thr_irq, retrig_req}), 0);
    chk(int'(acc_value) == m_acc, "R11 acc", int'(acc_value), m_acc);
    chk(int'(out_value) == e_out, "R11 out", int'(out_value), e_out);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd9137));
    repeat (3) @(negedge clk);
    chk(out_value == 0 && acc_value == 0 && sample_count == 0, "R1 values", int'(acc_value), 0);
    chk(!out_valid && !thr_irq && !retrig_req, "R1 strobes", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R7 basic pass-through under each condition code
    for (int c = 0; c < 4; c++) begin
      cfg(0, 0, -10, 10, c);
      push(-20, "R7"); push(0, "R7"); push(20, "R7");
    end
    push(-2048, "R2");
    chk(int'(out_value) == -2048, "R2 sign", int'(out_value), -2048);
    idle_check();

    // R8 positive and negative saturation in accumulate mode
    cfg(1, 0, 0, 0, 0);
    for (int i = 0; i < 70; i++) push(2047, "R3");
    chk(int'(acc_value) == 131071, "R8 pos", int'(acc_value), 131071);
    chk(!thr_irq, "R3 no irq", int'(thr_irq), 0);
    cfg(0, 0, 0, 0, 0); push(1, "R10");
    cfg(1, 0, 0, 0, 0);
    push(-5, "R10");
    chk(int'(acc_value) == -5, "R10 restart", int'(acc_value), -5);
    for (int i = 0; i < 70; i++) push(-2048, "R3");
    chk(int'(acc_value) == -131072, "R8 neg", int'(acc_value), -131072);
    // R9 counter saturation
    for (int i = 0; i < 200; i++) push(0, "R3");
    chk(int'(sample_count) == 255, "R9", int'(sample_count), 255);

    // R4 average, positive and negative, then restart
    cfg(2, 2, -1000, 1000, 2);
    push(10, "R4"); push(20, "R4"); push(30, "R4");
    chk(!out_valid, "R4 early", int'(out_valid), 0);
    push(41, "R4");
    chk(int'(out_value) == 25 && out_valid, "R4 avg", int'(out_value), 25);
    push(-1, "R4");
    chk(int'(acc_value) == -1 && sample_count == 1, "R4 restart", int'(acc_value), -1);
    push(-1, "R4"); push(-1, "R4"); push(-2, "R4");
    chk(int'(out_value) == -2, "R4 floor", int'(out_value), -2);

    // R5 burst retrigger
    cfg(3, 3, 0, 0, 1);
    for (int i = 0; i < 7; i++) begin
      push(100 + i, "R5");
      chk(retrig_req, "R5 retrig", int'(retrig_req), 1);
    end
    push(100, "R5");
    chk(!retrig_req && out_valid, "R5 last", int'(retrig_req), 0);
    idle_check();

    // R6 low-pass settling on a constant input
    cfg(4, 2, 0, 50, 1);
    for (int i = 0; i < 40; i++) push(100, "R6");
    chk(int'(out_value) >= 96 && int'(out_value) <= 100, "R6 settle", int'(out_value), 100);

    // R10 mode change mid-average
    cfg(2, 2, 0, 0, 0); push(7, "R10"); push(8, "R10");
    cfg(1, 0, 0, 0, 0); push(9, "R10");
    chk(int'(acc_value) == 9 && sample_count == 1, "R10", int'(acc_value), 9);

    // random blocks
    for (int blk = 0; blk < 60; blk++) begin
      int md, n;
      md = int'($urandom_range(0, 4));
      cfg(md, int'($urandom_range(0, 3)), int'($urandom_range(0, 600)) - 300,
          int'($urandom_range(0, 600)) - 100, int'($urandom_range(0, 3)));
      n = int'($urandom_range(1, 20));
      for (int s = 0; s < n; s++) push(int'($urandom_range(0, 4095)) - 2048, tag_of(md));
      if (blk % 10 == 0) idle_check();
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule